// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor

This block is a small processor with no opcode field. Every instruction is a pair of words, a source address and a destination address, and executing it copies the value read from the source to the destination. Arithmetic, jumps and halting are side effects of moving values to reserved low addresses. Two of these addresses are ALU operand registers, and four are read-only result ports that always reflect those operands. Address 0 is the program counter, and address 7 is a halt port. All other traffic goes to an external RAM.

The external RAM holds both the program and the data. It sits on one single-port memory port with a combinational read path. Each move takes four clock cycles: fetch the source word, fetch the destination word, read the value, write the value. When the top bit of a source word is set, the remaining bits are a literal instead of an address, so `literal -> PC` is an immediate jump. A conditional branch has no direct form. The program adds the zero flag to a table base through the ALU, writes the sum into the source word of a later `-> PC` move, and so jumps through a two-entry table.

Top module: `mover_cpu`

## Requirements
- R1: While `rst_ni` is low, `halted_o` is 0, `mem_we_o` is 0 and `mem_addr_o` equals `RESET_PC` (default 8), the address of the first instruction.
- R2: An instruction is the source word at PC followed by the destination word at PC+1. A move takes exactly four cycles. A move between two RAM addresses (8 and above) copies the value, and PC then advances by 2.
- R3: A source word with bit 15 set is a literal. The moved value is bits 14:0 zero-extended, so `0x7FFF` is the largest literal.
- R4: Writing to address 0 loads PC with the moved value, so execution continues there instead of at PC+2. A literal source gives an immediate jump.
- R5: Address 1 is ALU operand A and address 2 is operand B, and both can be read back. Reading address 3 gives A+B, address 4 gives A-B modulo 2^16, and address 5 gives A AND B.
- R6: Reading address 6 gives 1 when A equals B, otherwise 0.
- R7: Addresses 3 to 6 are read-only. A move to them changes no result and causes no external write. `mem_we_o` is only asserted for addresses 8 and above.
- R8: Any move to address 7 stops execution. `halted_o` then goes high and stays high, and no further memory write occurs until reset.
- R9: Reading address 0 returns the address of the executing instruction. Reading address 7 returns 0.
- R10: Words written to RAM are fetched with their new value. A conditional branch formed by patching a later instruction's source word with table base plus zero flag takes the equal path when the operands match, and the other path when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | DATA_W | External RAM address (fetch, read or write) |
| mem_rdata_i | input | DATA_W | External RAM read data, combinational from `mem_addr_o` |
| mem_we_o | output | 1 | External RAM write enable |
| mem_wdata_o | output | DATA_W | External RAM write data |
| halted_o | output | 1 | High once a move to the halt port has executed |

## Verification
The bench uses the default parameters: `DATA_W` = 16 and `RESET_PC` = 8. With a 16-bit word, the subtraction wrap (1-2 giving 0xFFFF) and the largest 15-bit literal (0x7FFF) are both easy to reach. The bench RAM has 256 words, so programs, the branch table and the data all lie in addresses 8 to 255, which puts the self-patched branch within reach of short directed programs. Cycle counts to halt are measured from reset release, which pins the four-cycle move timing.

// File: rtl/mover_pkg.sv
package mover_pkg;
  typedef enum logic [2:0] {
    ST_FSRC,
    ST_FDST,
    ST_LOAD,
    ST_STORE,
    ST_HALT
  } state_e;

  localparam logic [2:0] ADR_PC   = 3'd0;
  localparam logic [2:0] ADR_OPA  = 3'd1;
  localparam logic [2:0] ADR_OPB  = 3'd2;
  localparam logic [2:0] ADR_ADD  = 3'd3;
  localparam logic [2:0] ADR_SUB  = 3'd4;
  localparam logic [2:0] ADR_AND  = 3'd5;
  localparam logic [2:0] ADR_ZF   = 3'd6;
  localparam logic [2:0] ADR_HALT = 3'd7;
  localparam int         ADR_RAM  = 8;
endpackage

// File: rtl/mover_alu.sv
module mover_alu #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o,
  output logic [DATA_W-1:0] and_o,
  output logic              zf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '0;
    end else begin
      if (wr_a_i) a_o <= wdata_i;
      if (wr_b_i) b_o <= wdata_i;
    end
  end

  assign sum_o  = a_o + b_o;
  assign diff_o = a_o - b_o;
  assign and_o  = a_o & b_o;
  assign zf_o   = (a_o == b_o);

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_a_i && !wr_b_i) |=> (sum_o == $past(sum_o) && diff_o == $past(diff_o))) else $error("results changed"); // R7
  AST_ZF_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zf_o |-> (diff_o == '0)) else $error("zero flag mismatch"); // R6
endmodule

// File: rtl/mover_decode.sv
module mover_decode
  import mover_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [DATA_W-1:0] diff_i,
  input  logic [DATA_W-1:0] and_i,
  input  logic              zf_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              wr_pc_o,
  output logic              wr_a_o,
  output logic              wr_b_o,
  output logic              wr_halt_o
);
  localparam logic [DATA_W-1:0] RAM_BASE = DATA_W'(ADR_RAM);

  logic              src_lit, src_ram, dst_ram, store_sp;
  logic [DATA_W-1:0] sp_val;

  assign src_lit  = src_i[DATA_W-1];
  assign src_ram  = !src_lit && (src_i >= RAM_BASE);
  assign dst_ram  = dst_i >= RAM_BASE;
  assign store_sp = (state_i == ST_STORE) && !dst_ram;

  always_comb begin
    unique case (src_i[2:0])
      ADR_PC:   sp_val = pc_i;
      ADR_OPA:  sp_val = a_i;
      ADR_OPB:  sp_val = b_i;
      ADR_ADD:  sp_val = sum_i;
      ADR_SUB:  sp_val = diff_i;
      ADR_AND:  sp_val = and_i;
      ADR_ZF:   sp_val = {{(DATA_W-1){1'b0}}, zf_i};
      default:  sp_val = '0;
    endcase
  end

  always_comb begin
    if (src_lit)      load_val_o = {1'b0, src_i[DATA_W-2:0]};
    else if (src_ram) load_val_o = rdata_i;
    else              load_val_o = sp_val;
  end

  always_comb begin
    mem_we_o = 1'b0;
    unique case (state_i)
      ST_FSRC:  mem_addr_o = pc_i;
      ST_FDST:  mem_addr_o = pc_i + DATA_W'(1);
      ST_LOAD:  mem_addr_o = src_i;
      ST_STORE: begin
        mem_addr_o = dst_i;
        mem_we_o   = dst_ram;
      end
      default:  mem_addr_o = pc_i;
    endcase
  end

  assign wr_pc_o   = store_sp && (dst_i[2:0] == ADR_PC);
  assign wr_a_o    = store_sp && (dst_i[2:0] == ADR_OPA);
  assign wr_b_o    = store_sp && (dst_i[2:0] == ADR_OPB);
  assign wr_halt_o = store_sp && (dst_i[2:0] == ADR_HALT);

  AST_WE_RAM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= RAM_BASE)) else $error("write below RAM"); // R7
  AST_WE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(state_i == ST_LOAD)) else $error("write outside store"); // R2
endmodule

// File: rtl/mover_seq.sv
module mover_seq
  import mover_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RESET_PC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              wr_pc_i,
  input  logic              wr_halt_i,
  output state_e            state_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dst_o,
  output logic [DATA_W-1:0] val_o,
  output logic              halted_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_FSRC;
      pc_o    <= DATA_W'(RESET_PC);
      src_o   <= '0;
      dst_o   <= '0;
      val_o   <= '0;
    end else begin
      unique case (state_o)
        ST_FSRC: begin
          src_o   <= rdata_i;
          state_o <= ST_FDST;
        end
        ST_FDST: begin
          dst_o   <= rdata_i;
          state_o <= ST_LOAD;
        end
        ST_LOAD: begin
          val_o   <= load_val_i;
          state_o <= ST_STORE;
        end
        ST_STORE: begin
          if (wr_halt_i) begin
            state_o <= ST_HALT;
          end else begin
            pc_o    <= wr_pc_i ? val_o : pc_o + DATA_W'(2);
            state_o <= ST_FSRC;
          end
        end
        default: state_o <= ST_HALT;
      endcase
    end
  end

  assign halted_o = (state_o == ST_HALT);

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_STORE && !wr_pc_i && !wr_halt_i) |=> (pc_o == $past(pc_o) + DATA_W'(2))) else $error("pc step"); // R2
  AST_PC_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_STORE && wr_pc_i) |=> (pc_o == $past(val_o))) else $error("pc jump"); // R4
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o))) else $error("halt left"); // R8
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_STORE) |=> $stable(pc_o)) else $error("pc moved mid move"); // R2
endmodule

// File: rtl/mover_cpu.sv
module mover_cpu
  import mover_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RESET_PC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              halted_o
);
  state_e            state;
  logic [DATA_W-1:0] pc, src, dst, val, load_val;
  logic [DATA_W-1:0] op_a, op_b, sum, diff, andv;
  logic              zf, wr_pc, wr_a, wr_b, wr_halt;

  mover_seq #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rdata_i    (mem_rdata_i),
    .load_val_i (load_val),
    .wr_pc_i    (wr_pc),
    .wr_halt_i  (wr_halt),
    .state_o    (state),
    .pc_o       (pc),
    .src_o      (src),
    .dst_o      (dst),
    .val_o      (val),
    .halted_o   (halted_o)
  );

  mover_decode #(.DATA_W(DATA_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .pc_i       (pc),
    .src_i      (src),
    .dst_i      (dst),
    .val_i      (val),
    .rdata_i    (mem_rdata_i),
    .a_i        (op_a),
    .b_i        (op_b),
    .sum_i      (sum),
    .diff_i     (diff),
    .and_i      (andv),
    .zf_i       (zf),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .load_val_o (load_val),
    .wr_pc_o    (wr_pc),
    .wr_a_o     (wr_a),
    .wr_b_o     (wr_b),
    .wr_halt_o  (wr_halt)
  );

  mover_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_a_i  (wr_a),
    .wr_b_i  (wr_b),
    .wdata_i (val),
    .a_o     (op_a),
    .b_o     (op_b),
    .sum_o   (sum),
    .diff_o  (diff),
    .and_o   (andv),
    .zf_o    (zf)
  );

  assign mem_wdata_o = val;

  AST_NO_WRITE_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o) else $error("write while halted"); // R8
endmodule

// File: tb/mover_cpu_test.sv
`timescale 1ns/1ps
module mover_cpu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we, halted;
  logic [15:0] mem [0:255];
  int          checks = 0;
  int          fails = 0;
  int          we_halted = 0;
  int          wp = 8;

  always #2.5 clk = ~clk;

  mover_cpu uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .halted_o    (halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (rst_ni && halted && mem_we) we_halted++;
  end

  function automatic logic [15:0] lit(input int v);
    return 16'h8000 | 16'(v);
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic emit(input logic [15:0] s, input logic [15:0] d);
    mem[wp]   = s;
    mem[wp+1] = d;
    wp += 2;
  endtask

  task automatic clear_prog();
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    wp = 8;
    we_halted = 0;
  endtask

  task automatic run(output int cycles);
    cycles = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    while (cycles < 2000) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      if (halted) break;
    end
    if (!halted) check("R8", "halt reached", 16'(halted), 16'd1);
  endtask

  task automatic t_reset();
    clear_prog();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "halted in reset", 16'(halted), 16'd0);
    check("R1", "we in reset", 16'(mem_we), 16'd0);
    check("R1", "first fetch address", mem_addr, 16'd8);
  endtask

  task automatic t_move_literal_halt();
    int n;
    clear_prog();
    mem[100] = 16'h1234;
    mem[122] = 16'h00aa;
    emit(16'd100, 16'd101);
    emit(lit(16'h7fff), 16'd123);
    emit(lit(0), 16'd7);
    emit(lit(9), 16'd122);
    run(n);
    check("R2", "ram to ram copy", mem[101], 16'h1234);
    check("R2", "three moves take twelve cycles", 16'(n), 16'd12);
    check("R3", "largest literal", mem[123], 16'h7fff);
    repeat (10) @(negedge clk);
    check("R8", "halted stays high", 16'(halted), 16'd1);
    check("R8", "move after halt not run", mem[122], 16'h00aa);
    check("R8", "no write while halted", 16'(we_halted), 16'd0);
  endtask

  task automatic t_alu();
    int n;
    int pc_at;
    clear_prog();
    mem[118] = 16'h5555;
    emit(lit(300), 16'd1);
    emit(lit(45), 16'd2);
    emit(16'd3, 16'd110);
    emit(16'd4, 16'd111);
    emit(16'd5, 16'd112);
    emit(16'd6, 16'd113);
    emit(16'd1, 16'd124);
    emit(16'd2, 16'd125);
    emit(lit(5), 16'd3);
    emit(lit(5), 16'd4);
    emit(lit(5), 16'd5);
    emit(lit(1), 16'd6);
    emit(16'd3, 16'd114);
    emit(16'd6, 16'd119);
    pc_at = wp;
    emit(16'd0, 16'd117);
    emit(16'd7, 16'd118);
    emit(lit(1), 16'd1);
    emit(lit(2), 16'd2);
    emit(16'd4, 16'd115);
    emit(lit(2), 16'd1);
    emit(16'd6, 16'd116);
    emit(lit(0), 16'd7);
    run(n);
    check("R5", "sum", mem[110], 16'd345);
    check("R5", "difference", mem[111], 16'd255);
    check("R5", "and", mem[112], 16'd44);
    check("R5", "read operand A", mem[124], 16'd300);
    check("R5", "read operand B", mem[125], 16'd45);
    check("R5", "subtract wraps", mem[115], 16'hffff);
    check("R6", "zero flag unequal", mem[113], 16'd0);
    check("R6", "zero flag equal", mem[116], 16'd1);
    check("R7", "sum after result writes", mem[114], 16'd345);
    check("R7", "zero flag after write", mem[119], 16'd0);
    check("R7", "low addresses untouched", mem[3], 16'd0);
    check("R9", "pc read", mem[117], 16'(pc_at));
    check("R9", "halt port reads zero", mem[118], 16'd0);
  endtask

  task automatic t_jump();
    int n;
    clear_prog();
    emit(lit(40), 16'd0);
    emit(lit(1), 16'd120);
    wp = 40;
    emit(lit(7), 16'd121);
    emit(lit(0), 16'd7);
    run(n);
    check("R4", "skipped move", mem[120], 16'd0);
    check("R4", "target move", mem[121], 16'd7);
    check("R4", "jump timing", 16'(n), 16'd12);
  endtask

  task automatic t_branch(input logic [15:0] x, input logic [15:0] y, input logic [15:0] exp);
    int n;
    int jmp_at;
    clear_prog();
    mem[130] = x;
    mem[131] = y;
    mem[140] = 16'd60;
    mem[141] = 16'd70;
    emit(16'd130, 16'd1);
    emit(16'd131, 16'd2);
    emit(16'd6, 16'd1);
    emit(lit(140), 16'd2);
    jmp_at = wp + 2;
    emit(16'd3, 16'(jmp_at));
    emit(16'd0, 16'd0);
    emit(lit(3), 16'd150);
    emit(lit(0), 16'd7);
    wp = 60;
    emit(lit(2), 16'd150);
    emit(lit(0), 16'd7);
    wp = 70;
    emit(lit(1), 16'd150);
    emit(lit(0), 16'd7);
    run(n);
    check("R10", "branch path", mem[150], exp);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_move_literal_halt();
    t_alu();
    t_jump();
    t_branch(16'd5, 16'd5, 16'd1);
    t_branch(16'd5, 16'd6, 16'd2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule